// File: doc/BRIEF.md
# Read Strobe Window Training FSM

This block calibrates where the internal read-enable pulse sits for each data strobe group. It steps through 32 candidate positions. Each position pairs a 2-bit coarse setting with a 3-bit fine setting, and each fine step moves the pulse by a quarter of a clock period. At each position the block asks the command path for a number of read bursts. During every burst it holds the settings steady, then samples one burst-detect flag per group. A group keeps the first position at which every trial read saw its flag.

All groups are swept together. A group that has locked shows its stored result on its outputs, and groups still searching show the position under test. The sweep stops early once every group has locked. If the last position is reached with any group still unlocked, the block reports an error.

Training starts in two ways: a one-cycle pulse that the initialization sequencer sends once initialization (and write leveling, if used) has finished, or a user retraining request. The user request follows a request/active/done/error handshake. While `train_act` is high the command path must put only NOP commands on the memory bus. Read requests toward the command path use valid/ready. Once `rd_valid` is raised it stays high, and every setting stays fixed, until `rd_ready` accepts it. The command path may therefore stall for as long as it needs.

Top module: `rsw_train_top`

## Requirements
- R1: Positions are visited in index order from 0 to 31, where index = coarse*8 + fine. The fine setting runs 0 to 7 inside each coarse step, and the coarse setting runs 0 to 3. `grp_coarse` holds bits [2g+1:2g] for group g and `grp_fine` holds bits [3g+2:3g].
- R2: Each position gets TRIALS accepted reads. A group locks at a position only if its `det_hit` bit was high at the end of every one of those reads, so a single miss moves that group on to the next position. A locked group keeps the first passing index.
- R3: From the cycle after a read is accepted, the settings of every group stay unchanged for BURST_CYC cycles.
- R4: `rd_valid` is raised only while training is active. While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and the settings do not change.
- R5: When the block is idle, an `init_go` pulse or a high `retrain_req` starts training. `train_act` rises in the next cycle and stays high continuously up to and including the single cycle in which `train_done` is high. It falls in the cycle after that.
- R6: The sweep ends once every group has locked. The total number of accepted reads is then (highest lock index + 1) * TRIALS.
- R7: If index 31 completes with a group still unlocked, `train_err` rises together with `train_done` after 32*TRIALS reads. It stays high until the next start. An unlocked group keeps the result it held before that run.
- R8: After reset all settings are zero and `train_act`, `train_done`, `train_err` and `rd_valid` are low.
- R9: Outside training, each group's outputs show its stored result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_go | input | 1 | One-cycle start pulse after initialization |
| retrain_req | input | 1 | User retraining request, held until `train_done` |
| train_act | output | 1 | Training in progress |
| train_done | output | 1 | One-cycle end-of-training pulse |
| train_err | output | 1 | No passing position for at least one group |
| rd_valid | output | 1 | Training read request to the command path |
| rd_ready | input | 1 | Command path accepts the read request |
| det_hit | input | NUM_GRP | Per-group burst-detect flag, sampled at the end of each read window |
| grp_coarse | output | 2*NUM_GRP | Coarse pulse position per group |
| grp_fine | output | 3*NUM_GRP | Fine pulse select per group |

## Verification
The hardest case to reach from the ports is a group whose window holds a single position and which misses on only one trial there, in particular the last trial of that position. Every other trial passes, so a design that checks only part of the trial set would wrongly lock. The bench models the strobe capture as a window of indices for each group and counts accepted reads. It withholds one group's detect flag on one chosen read number, which places a lone miss on an exact trial of an exact position. Alternate runs toggle `rd_ready` so that read requests sit stalled, which tests that the settings hold still while a request waits.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  localparam int CRS_W = 2;
  localparam int FIN_W = 3;
  localparam int POS_W = CRS_W + FIN_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_HOLD,
    ST_DONE
  } rsw_state_e;
endpackage

// File: rtl/rsw_sweep_ctr.sv
module rsw_sweep_ctr
  import rsw_pkg::*;
#(
  parameter int TRIALS = 8,
  localparam int TW = (TRIALS > 1) ? $clog2(TRIALS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [POS_W-1:0] pos_o,
  output logic             last_trial_o,
  output logic             last_pos_o
);
  logic [TW-1:0]    trial_q;
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      pos_q   <= '0;
    end else if (clr_i) begin
      trial_q <= '0;
      pos_q   <= '0;
    end else if (step_i) begin
      if (last_trial_o) begin
        trial_q <= '0;
        pos_q   <= pos_q + 1'b1;
      end else begin
        trial_q <= trial_q + 1'b1;
      end
    end
  end

  assign pos_o        = pos_q;
  assign last_trial_o = (trial_q == TW'(TRIALS - 1));
  assign last_pos_o   = (pos_q == {POS_W{1'b1}});

  // R1
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && !last_trial_o) |=> $stable(pos_q));
endmodule

// File: rtl/rsw_group_slot.sv
module rsw_group_slot
  import rsw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             sample_i,
  input  logic             pos_end_i,
  input  logic             hit_i,
  input  logic             train_on_i,
  input  logic [POS_W-1:0] cur_pos_i,
  output logic             locked_o,
  output logic             pass_o,
  output logic [POS_W-1:0] setting_o
);
  logic             locked_q;
  logic             miss_q;
  logic [POS_W-1:0] store_q;

  assign pass_o = !locked_q && !miss_q && hit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      miss_q   <= 1'b0;
      store_q  <= '0;
    end else if (clr_i) begin
      locked_q <= 1'b0;
      miss_q   <= 1'b0;
    end else if (sample_i) begin
      if (pos_end_i) begin
        miss_q <= 1'b0;
        if (pass_o) begin
          locked_q <= 1'b1;
          store_q  <= cur_pos_i;
        end
      end else begin
        miss_q <= miss_q | ~hit_i;
      end
    end
  end

  assign locked_o  = locked_q;
  assign setting_o = (train_on_i && !locked_q) ? cur_pos_i : store_q;

  // R2
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !clr_i) |=> (locked_q && $stable(store_q)));
endmodule

// File: rtl/rsw_train_top.sv
module rsw_train_top
  import rsw_pkg::*;
#(
  parameter int NUM_GRP   = 2,
  parameter int TRIALS    = 8,
  parameter int BURST_CYC = 4,
  localparam int BW = (BURST_CYC > 1) ? $clog2(BURST_CYC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     init_go,
  input  logic                     retrain_req,
  output logic                     train_act,
  output logic                     train_done,
  output logic                     train_err,
  output logic                     rd_valid,
  input  logic                     rd_ready,
  input  logic [NUM_GRP-1:0]       det_hit,
  output logic [CRS_W*NUM_GRP-1:0] grp_coarse,
  output logic [FIN_W*NUM_GRP-1:0] grp_fine
);
  rsw_state_e       state_q, state_d;
  logic [BW-1:0]    beat_q;
  logic             err_q;
  logic             start, sample, last_beat;
  logic             last_trial, last_pos;
  logic [POS_W-1:0] cur_pos;
  logic [NUM_GRP-1:0] locked, pass;
  logic             all_next;

  assign start     = (state_q == ST_IDLE) && (init_go || retrain_req);
  assign last_beat = (beat_q == BW'(BURST_CYC - 1));
  assign sample    = (state_q == ST_HOLD) && last_beat;
  assign all_next  = &(locked | (pass & {NUM_GRP{last_trial}}));

  rsw_sweep_ctr #(.TRIALS(TRIALS)) u_ctr (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (start),
    .step_i       (sample),
    .pos_o        (cur_pos),
    .last_trial_o (last_trial),
    .last_pos_o   (last_pos)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_slot
    logic [POS_W-1:0] setting;
    rsw_group_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (start),
      .sample_i   (sample),
      .pos_end_i  (last_trial),
      .hit_i      (det_hit[g]),
      .train_on_i (train_act),
      .cur_pos_i  (cur_pos),
      .locked_o   (locked[g]),
      .pass_o     (pass[g]),
      .setting_o  (setting)
    );
    assign grp_coarse[CRS_W*g +: CRS_W] = setting[POS_W-1:FIN_W];
    assign grp_fine[FIN_W*g +: FIN_W]   = setting[FIN_W-1:0];
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_ISSUE;
      ST_ISSUE: if (rd_ready) state_d = ST_HOLD;
      ST_HOLD: begin
        if (last_beat) begin
          if (last_trial && (all_next || last_pos)) state_d = ST_DONE;
          else                                      state_d = ST_ISSUE;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_HOLD) beat_q <= last_beat ? '0 : beat_q + 1'b1;
      else                    beat_q <= '0;
      if (start)
        err_q <= 1'b0;
      else if (sample && last_trial && last_pos && !all_next)
        err_q <= 1'b1;
    end
  end

  assign train_act  = (state_q != ST_IDLE);
  assign train_done = (state_q == ST_DONE);
  assign train_err  = err_q;
  assign rd_valid   = (state_q == ST_ISSUE);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(grp_coarse) && $stable(grp_fine)));

  // R3
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !last_beat) |=> ($stable(grp_coarse) && $stable(grp_fine)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    train_done |=> (!train_act && !train_done));

  // R7
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_err) |-> train_done);

  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(train_err) |-> train_act);
endmodule

// File: tb/tb_rsw_train_top.sv
module tb_rsw_train_top;
  localparam int NG = 2;
  localparam int TR = 8;
  localparam int BC = 4;
  localparam int NROW = 5;
  // columns: lo0 hi0 lo1 hi1 miss_idx miss_grp use_init exp0 exp1 exp_err exp_reads
  localparam int VEC [0:NROW-1][0:10] = '{
    '{ 5,  9, 12, 20, -1, 0, 1,  5, 12, 0, 104},
    '{ 5,  9,  0,  3, 43, 0, 0,  6,  0, 0,  56},
    '{31, 31, 24, 28, -1, 0, 0, 31, 24, 0, 256},
    '{40, 40,  2,  2, -1, 0, 1, 31,  2, 1, 256},
    '{ 8,  8,  7,  7, 63, 1, 0,  8,  2, 1, 256}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_go = 1'b0;
  logic retrain_req = 1'b0;
  logic rd_ready = 1'b1;
  logic stall = 1'b0;
  logic train_act, train_done, train_err, rd_valid;
  logic [NG-1:0] det_hit;
  logic [2*NG-1:0] grp_coarse;
  logic [3*NG-1:0] grp_fine;

  int checks = 0, fails = 0;
  int lo [NG], hi [NG];
  int miss_idx = -1, miss_grp = 0;
  int reads = 0;
  int viol_hold = 0, viol_valid = 0, viol_stall = 0, viol_act = 0;

  always #4 clk = ~clk;

  rsw_train_top #(.NUM_GRP(NG), .TRIALS(TR), .BURST_CYC(BC)) dut (
    .clk(clk), .rst_n(rst_n), .init_go(init_go), .retrain_req(retrain_req),
    .train_act(train_act), .train_done(train_done), .train_err(train_err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .det_hit(det_hit),
    .grp_coarse(grp_coarse), .grp_fine(grp_fine)
  );

  function automatic int pos_of(int g);
    return grp_coarse[2*g +: 2] * 8 + grp_fine[3*g +: 3];
  endfunction

  always_comb begin
    for (int g = 0; g < NG; g++) begin
      det_hit[g] = (pos_of(g) >= lo[g]) && (pos_of(g) <= hi[g]) &&
                   !(g == miss_grp && reads == miss_idx + 1);
    end
  end

  always @(posedge clk) begin
    if (rd_valid && rd_ready) reads <= reads + 1;
    rd_ready <= stall ? ~rd_ready : 1'b1;
  end

  // Monitors (R3, R4, R5)
  logic armed = 1'b0;
  int hold_left = 0;
  logic [2*NG-1:0] ref_c;
  logic [3*NG-1:0] ref_f;
  logic prev_stall = 1'b0, prev_act = 1'b0, prev_done = 1'b0;
  always @(posedge clk) armed <= rd_valid && rd_ready;
  always @(negedge clk) begin
    if (rst_n) begin
      if (armed) begin
        ref_c = grp_coarse; ref_f = grp_fine; hold_left = BC - 1;
      end else if (hold_left > 0) begin
        if (grp_coarse !== ref_c || grp_fine !== ref_f) viol_hold++;
        hold_left--;
      end
      if (rd_valid && !train_act) viol_valid++;
      if (prev_stall && (!rd_valid || grp_coarse !== ref_c || grp_fine !== ref_f)) viol_stall++;
      if (prev_act && !train_act && !prev_done) viol_act++;
      prev_stall = rd_valid && !rd_ready;
      if (prev_stall) begin ref_c = grp_coarse; ref_f = grp_fine; end
      prev_act = train_act; prev_done = train_done;
    end else begin
      prev_stall = 1'b0; prev_act = 1'b0; prev_done = 1'b0; hold_left = 0;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_row(int r);
    int wait_cyc;
    logic err_at_done;
    lo[0] = VEC[r][0]; hi[0] = VEC[r][1];
    lo[1] = VEC[r][2]; hi[1] = VEC[r][3];
    miss_idx = VEC[r][4]; miss_grp = VEC[r][5];
    stall = r[0];
    @(negedge clk);
    reads = 0;
    if (VEC[r][6] == 1) begin
      init_go = 1'b1; @(negedge clk); init_go = 1'b0;
    end else begin
      retrain_req = 1'b1; @(negedge clk);
    end
    check("R5 act after start", int'(train_act), 1);
    wait_cyc = 0;
    while (!train_done && wait_cyc < 20000) begin @(negedge clk); wait_cyc++; end
    retrain_req = 1'b0;
    check("R5 done seen", int'(train_done), 1);
    err_at_done = train_err;
    @(negedge clk);
    check("R5 act low after done", int'(train_act), 0);
    check("R7 err", int'(err_at_done), VEC[r][9]);
    check("R1 R2 group0 result", pos_of(0), VEC[r][7]);
    check("R2 R9 group1 result", pos_of(1), VEC[r][8]);
    check("R6 read count", reads, VEC[r][10]);
    repeat (3) @(negedge clk);
    check("R7 err held idle", int'(train_err), VEC[r][9]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    lo[0] = 0; hi[0] = -1; lo[1] = 0; hi[1] = -1;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 act", int'(train_act), 0);
    check("R8 done", int'(train_done), 0);
    check("R8 err", int'(train_err), 0);
    check("R8 valid", int'(rd_valid), 0);
    check("R8 settings", int'({grp_coarse, grp_fine}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int r = 0; r < NROW; r++) run_row(r);
    // R3 R4 R5 monitor results
    check("R3 burst hold violations", viol_hold, 0);
    check("R4 valid outside training", viol_valid, 0);
    check("R4 stall hold violations", viol_stall, 0);
    check("R5 act gaps", viol_act, 0);
    // R1 first position shown at start, then reset mid-run (R8)
    lo[0] = 0; hi[0] = -1; lo[1] = 0; hi[1] = -1; miss_idx = -1; stall = 1'b0;
    init_go = 1'b1; @(negedge clk); init_go = 1'b0;
    check("R1 first index group0", pos_of(0), 0);
    check("R4 valid raised", int'(rd_valid), 1);
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 reset mid-run act", int'(train_act), 0);
    check("R8 reset mid-run settings", int'({grp_coarse, grp_fine}), 0);
    check("R8 reset mid-run valid", int'(rd_valid), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule